// File: doc/BRIEF.md
# SPI-Addressed Eight-Pin GPIO Port

This block is a serial-peripheral slave that owns the control registers of an eight-pin general-purpose I/O port. A host talks to it over a four-wire SPI link in mode 0. The clock idles low, data is sampled on the rising edge and changes on the falling edge, and every byte is sent most significant bit first. Several of these slaves may share a single chip select. Each one decides whether a frame belongs to it from a 3-bit device address carried in the first byte, and compares that address against its own strap pins when address matching is switched on.

Every frame starts with a command byte of the form `0 1 0 0 d2 d1 d0 rw`. The second byte selects a register. In a write frame each following byte is stored. In a read frame the slave returns register contents for as long as the host keeps clocking. The register pointer steps forward after every data byte and wraps from the last register back to the first, unless a configuration bit freezes it. The pads are modelled as separate input, output-value, output-enable and pull-up-enable vectors. The three interrupt-setup registers are driven out to a neighbouring interrupt block, and that block's flag and capture values are read back through two read-only registers.

The SPI lines and the pin inputs are oversampled by a fast system clock, so the whole block runs in a single clock domain.

Top module: `gpx_spi_top`

## Requirements
- R1: After reset the direction register (address 0x00) reads 0xFF, so every pad has its output enable low, and every other stored register reads 0x00. `misoOe` is low.
- R2: Frame format. Byte 0 is a command whose bits [7:4] must be 4'b0100, bits [3:1] hold the device address and bit 0 selects the direction (1 = read, 0 = write). Byte 1 is the register address, of which only bits [3:0] are used. Data bytes follow, all MSB first.
- R3: A value written to any of the storage registers 0x00–0x06 or 0x0A is returned by a later read of the same address.
- R4: `padOe[i]` is the inverse of direction bit i (0 = output), `padOut` equals the output latch (0x0A), and `padPullEn` equals the pull-up register (0x06). Pads change only when a register write takes effect.
- R5: A read of 0x09 returns the synchronised `pinIn` XOR the polarity register (0x01). A write to 0x09 is stored in the output latch (0x0A).
- R6: With configuration bit 5 (register 0x05) clear, the register address advances by one after each data byte and wraps from 0x0A to 0x00. The same rule applies from any address of 0x0A or above.
- R7: With configuration bit 5 set, every data byte of a frame uses the address given in byte 1.
- R8: With configuration bit 3 set, a frame is accepted only when command bits [3:1] equal `strapAddr`. With bit 3 clear, any device address is accepted. A command with the wrong upper nibble, or with a rejected address, leaves every register unchanged.
- R9: Writes to 0x07 and 0x08 are ignored. Those addresses read `irqFlags` and `irqCapture`. Addresses 0x0B–0x0F read 0x00 and ignore writes.
- R10: Raising `csn` abandons the frame in progress. A partly shifted byte is discarded, and the next frame starts again with a command byte.
- R11: Registers 0x02, 0x03 and 0x04 drive `irqEnable`, `irqCompare` and `irqMode` respectively.
- R12: `misoOe` is high only in the data phase of an accepted read frame, and it drops once `csn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rstN | input | 1 | Active-low synchronous reset |
| csn | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| misoOut | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for the host data line |
| strapAddr | input | 3 | Device address set by the strap pins |
| pinIn | input | 8 | Levels sensed at the pads |
| padOut | output | 8 | Value driven onto the pads |
| padOe | output | 8 | Per-pad output enable |
| padPullEn | output | 8 | Per-pad pull-up enable |
| irqFlags | input | 8 | Flag value from the interrupt block |
| irqCapture | input | 8 | Captured port value from the interrupt block |
| irqEnable | output | 8 | Per-pin interrupt enable |
| irqCompare | output | 8 | Per-pin compare value |
| irqMode | output | 8 | Per-pin compare-versus-change select |

## Verification
The assertions assume that `csn`, `sclk` and `mosi` change slowly compared with `clk`: each SCLK phase must last longer than the synchroniser depth plus one cycle. Under that condition a byte-complete event and a read-load cycle never coincide with a falling-edge shift, and a write strobe is always followed by at least eight quiet cycles before the next one. The bench meets this by holding every SCLK half-period for six system clocks and by leaving several idle clocks around each chip-select transition. It changes `pinIn` and the interrupt inputs only between frames, so the port value captured for a read is already settled.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int REG_W      = 8;
  localparam int PTR_W      = 4;
  localparam int DEV_ADDR_W = 3;
  localparam int NUM_REGS   = 11;
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

  localparam logic [PTR_W-1:0] ADR_DIR   = 4'h0;
  localparam logic [PTR_W-1:0] ADR_POL   = 4'h1;
  localparam logic [PTR_W-1:0] ADR_IEN   = 4'h2;
  localparam logic [PTR_W-1:0] ADR_CMP   = 4'h3;
  localparam logic [PTR_W-1:0] ADR_IMODE = 4'h4;
  localparam logic [PTR_W-1:0] ADR_CFG   = 4'h5;
  localparam logic [PTR_W-1:0] ADR_PULL  = 4'h6;
  localparam logic [PTR_W-1:0] ADR_FLAG  = 4'h7;
  localparam logic [PTR_W-1:0] ADR_CAP   = 4'h8;
  localparam logic [PTR_W-1:0] ADR_PORT  = 4'h9;
  localparam logic [PTR_W-1:0] ADR_LATCH = 4'hA;

  localparam int CFG_SEQ_BIT   = 5;
  localparam int CFG_HADDR_BIT = 3;
  localparam logic [3:0] CMD_OPCODE = 4'b0100;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic             wrStb;
    logic [PTR_W-1:0] wrAddr;
    logic [REG_W-1:0] wrData;
    logic [PTR_W-1:0] rdAddr;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gpx_spi_ctrl.sv
module gpx_spi_ctrl
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csn,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic [DEV_ADDR_W-1:0] strapAddr,
  input  logic                  seqDisable,
  input  logic                  hwAddrEn,
  input  logic [REG_W-1:0]      rdData,
  output ctrlStrobe_t           strb,
  output logic                  misoOut,
  output logic                  misoOe,
  output logic                  csActive
);
  localparam int BIT_W = $clog2(REG_W);

  logic [2:0] lineSync;
  logic csnS, sclkS, mosiS, sclkPrev;
  logic sclkRise, sclkFall, byteDone, cmdMatch, loadPending, isRead;
  logic [BIT_W-1:0] bitCnt;
  logic [REG_W-1:0] shiftIn, byteVal, txShift;
  logic [PTR_W-1:0] ptr;
  phase_t phase;

  gpx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_lineSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({csn, sclk, mosi}),
    .q   (lineSync)
  );

  assign csnS     = lineSync[2];
  assign sclkS    = lineSync[1];
  assign mosiS    = lineSync[0];
  assign csActive = !csnS;
  assign sclkRise = sclkS && !sclkPrev;
  assign sclkFall = !sclkS && sclkPrev;
  assign byteVal  = {shiftIn[REG_W-2:0], mosiS};
  assign byteDone = csActive && sclkRise && (bitCnt == BIT_W'(REG_W - 1));
  assign cmdMatch = (byteVal[REG_W-1 -: 4] == CMD_OPCODE) &&
                    (!hwAddrEn || (byteVal[DEV_ADDR_W:1] == strapAddr));

  function automatic logic [PTR_W-1:0] stepPtr(logic [PTR_W-1:0] p, logic hold);
    if (hold) return p;
    if (p >= LAST_REG) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt      <= '0;
      shiftIn     <= '0;
      txShift     <= '0;
      ptr         <= '0;
      phase       <= PH_CMD;
      isRead      <= 1'b0;
      loadPending <= 1'b0;
      misoOe      <= 1'b0;
      strb.wrStb  <= 1'b0;
      strb.wrAddr <= '0;
      strb.wrData <= '0;
    end else if (!csActive) begin
      bitCnt      <= '0;
      phase       <= PH_CMD;
      loadPending <= 1'b0;
      misoOe      <= 1'b0;
      strb.wrStb  <= 1'b0;
    end else begin
      strb.wrStb <= 1'b0;
      if (sclkRise) begin
        shiftIn <= byteVal;
        bitCnt  <= bitCnt + 1'b1;
      end
      if (byteDone) begin
        case (phase)
          PH_CMD: begin
            if (cmdMatch) begin
              phase  <= PH_ADDR;
              isRead <= byteVal[0];
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            phase       <= PH_DATA;
            ptr         <= byteVal[PTR_W-1:0];
            loadPending <= isRead;
          end
          PH_DATA: begin
            if (isRead) begin
              loadPending <= 1'b1;
            end else begin
              strb.wrStb  <= 1'b1;
              strb.wrAddr <= ptr;
              strb.wrData <= byteVal;
              ptr         <= stepPtr(ptr, seqDisable);
            end
          end
          default: ;
        endcase
      end
      if (loadPending) begin
        txShift     <= rdData;
        ptr         <= stepPtr(ptr, seqDisable);
        misoOe      <= 1'b1;
        loadPending <= 1'b0;
      end else if (sclkFall && (bitCnt != '0) && (phase == PH_DATA)) begin
        txShift <= {txShift[REG_W-2:0], 1'b0};
      end
    end
  end

  assign strb.rdAddr = ptr;
  assign misoOut     = txShift[REG_W-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [REG_W-1:0] pinSync,
  input  logic [REG_W-1:0] irqFlags,
  input  logic [REG_W-1:0] irqCapture,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] padOut,
  output logic [REG_W-1:0] padOe,
  output logic [REG_W-1:0] padPullEn,
  output logic [REG_W-1:0] irqEnable,
  output logic [REG_W-1:0] irqCompare,
  output logic [REG_W-1:0] irqMode,
  output logic             seqDisable,
  output logic             hwAddrEn
);
  logic [REG_W-1:0] dirReg, polReg, ienReg, cmpReg, imodeReg, cfgReg, pullReg, latReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= '1;
      polReg   <= '0;
      ienReg   <= '0;
      cmpReg   <= '0;
      imodeReg <= '0;
      cfgReg   <= '0;
      pullReg  <= '0;
      latReg   <= '0;
    end else if (strb.wrStb) begin
      case (strb.wrAddr)
        ADR_DIR:   dirReg   <= strb.wrData;
        ADR_POL:   polReg   <= strb.wrData;
        ADR_IEN:   ienReg   <= strb.wrData;
        ADR_CMP:   cmpReg   <= strb.wrData;
        ADR_IMODE: imodeReg <= strb.wrData;
        ADR_CFG:   cfgReg   <= strb.wrData;
        ADR_PULL:  pullReg  <= strb.wrData;
        ADR_PORT:  latReg   <= strb.wrData;
        ADR_LATCH: latReg   <= strb.wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (strb.rdAddr)
      ADR_DIR:   rdData = dirReg;
      ADR_POL:   rdData = polReg;
      ADR_IEN:   rdData = ienReg;
      ADR_CMP:   rdData = cmpReg;
      ADR_IMODE: rdData = imodeReg;
      ADR_CFG:   rdData = cfgReg;
      ADR_PULL:  rdData = pullReg;
      ADR_FLAG:  rdData = irqFlags;
      ADR_CAP:   rdData = irqCapture;
      ADR_PORT:  rdData = pinSync ^ polReg;
      ADR_LATCH: rdData = latReg;
      default:   rdData = '0;
    endcase
  end

  assign padOut     = latReg;
  assign padOe      = ~dirReg;
  assign padPullEn  = pullReg;
  assign irqEnable  = ienReg;
  assign irqCompare = cmpReg;
  assign irqMode    = imodeReg;
  assign seqDisable = cfgReg[CFG_SEQ_BIT];
  assign hwAddrEn   = cfgReg[CFG_HADDR_BIT];
endmodule

// File: rtl/gpx_spi_top.sv
module gpx_spi_top
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csn,
  input  logic                  sclk,
  input  logic                  mosi,
  output logic                  misoOut,
  output logic                  misoOe,
  input  logic [DEV_ADDR_W-1:0] strapAddr,
  input  logic [REG_W-1:0]      pinIn,
  output logic [REG_W-1:0]      padOut,
  output logic [REG_W-1:0]      padOe,
  output logic [REG_W-1:0]      padPullEn,
  input  logic [REG_W-1:0]      irqFlags,
  input  logic [REG_W-1:0]      irqCapture,
  output logic [REG_W-1:0]      irqEnable,
  output logic [REG_W-1:0]      irqCompare,
  output logic [REG_W-1:0]      irqMode
);
  ctrlStrobe_t      strb;
  logic [REG_W-1:0] rdData, pinSync;
  logic             seqDisable, hwAddrEn, csActive;

  gpx_sync #(.W(REG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pinSync (
    .clk (clk),
    .rstN(rstN),
    .d   (pinIn),
    .q   (pinSync)
  );

  gpx_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csn       (csn),
    .sclk      (sclk),
    .mosi      (mosi),
    .strapAddr (strapAddr),
    .seqDisable(seqDisable),
    .hwAddrEn  (hwAddrEn),
    .rdData    (rdData),
    .strb      (strb),
    .misoOut   (misoOut),
    .misoOe    (misoOe),
    .csActive  (csActive)
  );

  gpx_regfile u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pinSync   (pinSync),
    .irqFlags  (irqFlags),
    .irqCapture(irqCapture),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn),
    .irqEnable (irqEnable),
    .irqCompare(irqCompare),
    .irqMode   (irqMode),
    .seqDisable(seqDisable),
    .hwAddrEn  (hwAddrEn)
  );
endmodule

// File: rtl/gpx_spi_chk.sv
module gpx_spi_chk
  import gpx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             csActive,
  input logic             seqDisable,
  input ctrlStrobe_t      strb,
  input logic             misoOe,
  input logic [REG_W-1:0] padOut,
  input logic [REG_W-1:0] padOe,
  input logic [REG_W-1:0] padPullEn,
  input logic [REG_W-1:0] irqEnable
);
  AST_MISO_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !misoOe) else $error("misoOe high while deselected"); // R12

  AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> ($stable(padOut) && $stable(padOe) && $stable(padPullEn)))
    else $error("pads changed without a write"); // R4

  AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && ((strb.wrAddr == ADR_FLAG) || (strb.wrAddr == ADR_CAP))) |=>
      ($stable(padOut) && $stable(padOe) && $stable(padPullEn) && $stable(irqEnable)))
    else $error("read-only write had an effect"); // R9

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && seqDisable) |-> (strb.rdAddr == strb.wrAddr))
    else $error("pointer moved with sequencing disabled"); // R7

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && !seqDisable && (strb.wrAddr >= LAST_REG)) |-> (strb.rdAddr == '0))
    else $error("pointer did not wrap"); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && !seqDisable && (strb.wrAddr < LAST_REG)) |->
      (strb.rdAddr == strb.wrAddr + 1'b1))
    else $error("pointer did not advance"); // R6
endmodule

bind gpx_spi_top gpx_spi_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csActive  (csActive),
  .seqDisable(seqDisable),
  .strb      (strb),
  .misoOe    (misoOe),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullEn (padPullEn),
  .irqEnable (irqEnable)
);

// File: tb/gpx_spi_top_tb.sv
module gpx_spi_top_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [2:0] strapAddr = 3'd3;
  logic [7:0] pinIn = '0, irqFlags = '0, irqCapture = '0;
  logic misoOut, misoOe;
  logic [7:0] padOut, padOe, padPullEn, irqEnable, irqCompare, irqMode;

  int nChecks = 0, nFails = 0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  logic [7:0] expRegs [11];
  logic oeSeen;

  always #2 clk = ~clk;

  gpx_spi_top u_dut (
    .clk(clk), .rstN(rstN), .csn(csn), .sclk(sclk), .mosi(mosi),
    .misoOut(misoOut), .misoOe(misoOe), .strapAddr(strapAddr), .pinIn(pinIn),
    .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn),
    .irqFlags(irqFlags), .irqCapture(irqCapture),
    .irqEnable(irqEnable), .irqCompare(irqCompare), .irqMode(irqMode)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cmdByte(input logic [2:0] dev, input logic rd);
    return {4'b0100, dev, rd};
  endfunction

  function automatic int nextA(input int a, input logic hold);
    if (hold) return a;
    if (a >= 10) return 0;
    return a + 1;
  endfunction

  function automatic logic [7:0] expRead(input int a);
    case (a)
      7: return irqFlags;
      8: return irqCapture;
      9: return pinIn ^ expRegs[1];
      default: return (a <= 10) ? expRegs[a] : 8'h00;
    endcase
  endfunction

  function automatic bit accepted(input logic [7:0] cmd);
    return (cmd[7:4] == 4'b0100) && (!expRegs[5][3] || (cmd[3:1] == strapAddr));
  endfunction

  task automatic spiBits(input int nBits);
    csn = 1'b0; oeSeen = 1'b0;
    waitClk(HALF);
    for (int k = 0; k < nBits; k++) begin
      mosi = txb[k/8][7-(k%8)];
      waitClk(HALF);
      rxb[k/8][7-(k%8)] = misoOut;
      if (misoOe === 1'b1) oeSeen = 1'b1;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csn = 1'b1; mosi = 1'b0;
    waitClk(3*HALF);
  endtask

  task automatic doWrite(input logic [7:0] cmd, input int addr, input int n);
    int a;
    bit ok;
    ok = accepted(cmd);
    txb[0] = cmd; txb[1] = 8'(addr);
    spiBits((n + 2) * 8);
    if (ok) begin
      a = addr & 15;
      for (int i = 0; i < n; i++) begin
        logic hold;
        hold = expRegs[5][5];
        if (a <= 6 || a == 10) expRegs[a] = txb[2+i];
        else if (a == 9) expRegs[10] = txb[2+i];
        a = nextA(a, hold);
      end
    end
  endtask

  task automatic readCheck(input logic [7:0] cmd, input int addr, input int n, input string tag);
    int a;
    txb[0] = cmd; txb[1] = 8'(addr);
    for (int i = 0; i < n; i++) txb[2+i] = 8'h00;
    spiBits((n + 2) * 8);
    a = addr & 15;
    for (int i = 0; i < n; i++) begin
      check(rxb[2+i] == expRead(a), tag, rxb[2+i], expRead(a));
      a = nextA(a, expRegs[5][5]);
    end
  endtask

  task automatic checkPads(input string tag);
    check(padOe == ~expRegs[0], tag, padOe, ~expRegs[0]);
    check(padOut == expRegs[10], tag, padOut, expRegs[10]);
    check(padPullEn == expRegs[6], tag, padPullEn, expRegs[6]);
  endtask

  function automatic int pickAddr(input int r);
    case (r % 8)
      0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 4; 5: return 6; 6: return 9; default: return 10;
    endcase
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 11; i++) expRegs[i] = 8'h00;
    expRegs[0] = 8'hFF;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state
    check(padOe == 8'h00, "R1 padOe after reset", padOe, 8'h00);
    check(misoOe == 1'b0, "R12 misoOe after reset", {7'd0, misoOe}, 8'h00);
    check(irqEnable == 8'h00, "R1 irqEnable after reset", irqEnable, 8'h00);
    readCheck(cmdByte(3'd3, 1'b1), 0, 7, "R1 reset register values");
    check(oeSeen == 1'b1, "R12 misoOe in read data phase", {7'd0, oeSeen}, 8'h01);

    // R6 wrap on write, R4 pads, R2 frame format
    txb[2] = 8'hA5; txb[3] = 8'h0F;
    doWrite(cmdByte(3'd3, 1'b0), 10, 2);
    check(oeSeen == 1'b0, "R12 misoOe low in write frame", {7'd0, oeSeen}, 8'h00);
    checkPads("R6 R4 wrap write to latch then direction");

    // R11 interrupt setup outputs
    txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33;
    doWrite(cmdByte(3'd3, 1'b0), 2, 3);
    check(irqEnable == 8'h11, "R11 irqEnable", irqEnable, 8'h11);
    check(irqCompare == 8'h22, "R11 irqCompare", irqCompare, 8'h22);
    check(irqMode == 8'h33, "R11 irqMode", irqMode, 8'h33);
    txb[2] = 8'h3C;
    doWrite(cmdByte(3'd3, 1'b0), 6, 1);
    checkPads("R4 pull-up enables");
    readCheck(cmdByte(3'd3, 1'b1), 0, 7, "R3 readback of storage registers");
    readCheck(cmdByte(3'd3, 1'b1), 9, 3, "R6 read wraps past last register");

    // R5 port read with polarity, write to port lands in latch
    txb[2] = 8'h0F;
    doWrite(cmdByte(3'd3, 1'b0), 1, 1);
    pinIn = 8'h5A; waitClk(8);
    readCheck(cmdByte(3'd3, 1'b1), 9, 1, "R5 port read inverted by polarity");
    txb[2] = 8'h33;
    doWrite(cmdByte(3'd3, 1'b0), 9, 1);
    check(padOut == 8'h33, "R5 port write drives latch", padOut, 8'h33);
    readCheck(cmdByte(3'd3, 1'b1), 10, 1, "R5 latch readback");

    // R9 read-only and out of range
    irqFlags = 8'h81; irqCapture = 8'h42;
    txb[2] = 8'hFF; txb[3] = 8'hFF;
    doWrite(cmdByte(3'd3, 1'b0), 7, 2);
    readCheck(cmdByte(3'd3, 1'b1), 7, 2, "R9 flag and capture stay input-driven");
    checkPads("R9 read-only write left pads alone");
    txb[2] = 8'h77;
    doWrite(cmdByte(3'd3, 1'b0), 12, 1);
    readCheck(cmdByte(3'd3, 1'b1), 12, 1, "R9 out-of-range reads zero");
    checkPads("R9 out-of-range write ignored");

    // R7 sequencing disabled
    txb[2] = 8'h20;
    doWrite(cmdByte(3'd3, 1'b0), 5, 1);
    txb[2] = 8'h10; txb[3] = 8'h20; txb[4] = 8'h30;
    doWrite(cmdByte(3'd3, 1'b0), 10, 3);
    check(padOut == 8'h30, "R7 last byte wins at fixed address", padOut, 8'h30);
    checkPads("R7 neighbours untouched");
    readCheck(cmdByte(3'd3, 1'b1), 10, 3, "R7 repeated read of fixed address");
    txb[2] = 8'h00;
    doWrite(cmdByte(3'd3, 1'b0), 5, 1);

    // R8 hardware address matching
    txb[2] = 8'h08;
    doWrite(cmdByte(3'd3, 1'b0), 5, 1);
    txb[2] = 8'hEE;
    doWrite(cmdByte(3'd5, 1'b0), 10, 1);
    check(padOut == expRegs[10], "R8 mismatched device ignored", padOut, expRegs[10]);
    txb[2] = 8'h00;
    txb[0] = cmdByte(3'd5, 1'b1); txb[1] = 8'h0A;
    spiBits(24);
    check(oeSeen == 1'b0, "R12 R8 no drive for mismatched read", {7'd0, oeSeen}, 8'h00);
    txb[2] = 8'hEE;
    doWrite({4'b0110, 3'd3, 1'b0}, 10, 1);
    check(padOut == expRegs[10], "R8 bad opcode ignored", padOut, expRegs[10]);
    txb[2] = 8'hC3;
    doWrite(cmdByte(3'd3, 1'b0), 10, 1);
    check(padOut == 8'hC3, "R8 matched device accepted", padOut, 8'hC3);
    txb[2] = 8'h00;
    doWrite(cmdByte(3'd3, 1'b0), 5, 1);
    txb[2] = 8'h3C;
    doWrite(cmdByte(3'd6, 1'b0), 10, 1);
    check(padOut == 8'h3C, "R8 any address with matching off", padOut, 8'h3C);

    // R10 abort by chip select
    txb[0] = cmdByte(3'd3, 1'b0); txb[1] = 8'h0A; txb[2] = 8'hF0;
    spiBits(20);
    check(padOut == 8'h3C, "R10 partial byte discarded", padOut, 8'h3C);
    txb[0] = 8'hFF;
    spiBits(5);
    readCheck(cmdByte(3'd3, 1'b1), 10, 1, "R10 frame after abort decodes command");

    // random mix
    for (int it = 0; it < 100; it++) begin
      int a, n;
      pinIn = 8'($urandom); irqFlags = 8'($urandom); irqCapture = 8'($urandom);
      a = pickAddr(int'($urandom % 8));
      n = (a <= 4) ? 1 : 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) txb[2+i] = 8'($urandom);
      doWrite(cmdByte(3'($urandom), 1'b0), a, n);
      checkPads("R4 R3 random write pads");
      a = int'($urandom % 11);
      readCheck(cmdByte(3'd3, 1'b1), a, 1 + int'($urandom % 2), "R3 R5 R6 random readback");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule